// File: doc/BRIEF.md
# Data EEPROM Access Controller

This block sits on a CPU register bus and gives software byte-wide access to a small nonvolatile data store of up to 128 locations, modelled here as a behavioural cell array. Software loads a location pointer and a data byte, then starts either a read or a write by setting a start bit in a control register. A read finishes in one clock and leaves the stored byte in the data register. A write is self-timed: it lasts a programmable number of clocks, and the write start bit stays high while it runs.

A write starts only when two conditions hold. The write enable bit must already be set. The two bus writes just before the start must have put a two-byte key into a key register, which has no storage of its own. When a write completes, a sticky interrupt flag is raised. There are three reset inputs. Power-on reset clears everything. The master-clear and watchdog resets are warm resets: they leave the enable and error bits alone. If a warm reset cuts a write short, the error bit is set, the write is dropped and the stored byte is kept.

Top module: `nvm_access_ctrl`

## Requirements
- R1: Register select codes are 0 = pointer, 1 = data, 2 = control, 3 = key. The pointer register holds and reads back all 8 written bits, but the array decode uses only bits 6:0, so pointer values 0x85 and 0x05 reach the same location.
- R2: Control register layout: bit 0 = read start, bit 1 = write start, bit 2 = write enable, bit 3 = error flag. Bits 7:4 always read as 0.
- R3: Writing 1 to a start bit sets it. Writing 0 to a start bit never clears it; only the hardware clears it.
- R4: A read start is seen as 1 for exactly one cycle. On the next clock the data register holds the addressed byte and the read start bit reads 0.
- R5: A write keeps the write start bit at 1 for exactly WRITE_CYCLES cycles, then commits the byte. While it runs, bus writes to the pointer and data registers are ignored.
- R6: A write start is accepted only while the write enable bit is already 1. The write enable bit is 0 after power-on reset.
- R7: A write start is accepted only if the two bus writes just before it were 0x55 and then 0xAA to the key register. Any other bus write in between breaks the sequence.
- R8: Completion of a write sets irq_flag. It stays set until irq_clr is asserted; if completion and irq_clr come in the same cycle, the set wins.
- R9: The key register always reads as 0x00.
- R10: A master-clear or watchdog reset during a write sets the error flag and abandons the write, so the location keeps its old byte. It also clears the pointer, the data register and both start bits.
- R11: Power-on reset clears every register, including the error flag and write enable. A warm reset with no write in progress leaves the error flag and write enable unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, synchronous, active low |
| mclr_n | input | 1 | Master-clear warm reset, synchronous, active low |
| wdt_n | input | 1 | Watchdog warm reset, synchronous, active low |
| bus_we | input | 1 | Register write strobe |
| bus_sel | input | 2 | Register select |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Read data of the selected register (combinational) |
| irq_clr | input | 1 | Clears the completion flag |
| irq_flag | output | 1 | Sticky write-completion flag |

## Verification
The write path is tried in several ways:
- A correct key sequence, whose busy window is measured cycle by cycle.
- A key sequence broken by a stray data write, and one with the key bytes swapped. These show that the sequencer checks both adjacency and order.
- A correct sequence with the enable bit clear, which shows that the enable gate works on its own.

Bus writes issued during a write tell an ignored update apart from a silently accepted one, because the pointer, the data and the committed byte are all read back afterwards. Warm resets are applied both inside a write window and outside one, which separates "set the error flag" from "keep the error flag". Random writes and reads over a few locations, with bit 7 of the pointer set at random, check the aliasing of the address decode against a model of the array.

// File: rtl/nvm_pkg.sv
// Package nvm_pkg
// Shared encodings for the data EEPROM access controller: the register select
// codes, the bit positions inside the control register and the key sequencer
// states. Assumes an 8-bit CPU register bus.
package nvm_pkg;

    typedef enum logic [1:0] {
        SEL_PTR  = 2'd0,
        SEL_DATA = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_KEY  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        KEY_IDLE  = 2'd0,
        KEY_HALF  = 2'd1,
        KEY_ARMED = 2'd2
    } key_state_e;

    localparam int CTRL_RD   = 0;
    localparam int CTRL_WR   = 1;
    localparam int CTRL_WREN = 2;
    localparam int CTRL_ERR  = 3;

endpackage

// File: rtl/nvm_key_seq.sv
// Module nvm_key_seq
// Watches every bus write. It reports "armed" only when the two most recent
// writes were FIRST_KEY and then SECOND_KEY, both to the key register.
// Any other write drops back to idle. The next control write consumes the
// armed state. Assumes rst_n covers both power-on and warm resets.
module nvm_key_seq #(
    parameter int          BUS_BITS   = 8,
    parameter logic [7:0]  FIRST_KEY  = 8'h55,
    parameter logic [7:0]  SECOND_KEY = 8'hAA
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_we,
    input  logic [1:0]          bus_sel,
    input  logic [BUS_BITS-1:0] bus_wdata,
    output logic                armed
);
    import nvm_pkg::*;

    key_state_e state_q;
    logic       to_key;

    assign to_key = (bus_sel == SEL_KEY);

    // Advance the key sequence on each bus write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= KEY_IDLE;
        end else if (bus_we) begin
            if (to_key && bus_wdata == BUS_BITS'(FIRST_KEY)) begin
                state_q <= KEY_HALF;
            end else if (to_key && bus_wdata == BUS_BITS'(SECOND_KEY)
                         && state_q == KEY_HALF) begin
                state_q <= KEY_ARMED;
            end else begin
                state_q <= KEY_IDLE;
            end
        end
    end

    assign armed = (state_q == KEY_ARMED);

endmodule

// File: rtl/nvm_write_timer.sv
// Module nvm_write_timer
// Times one self-timed write. While the write runs, busy is high for exactly
// CYCLES clocks. done pulses in the last busy cycle, which is when the byte is
// committed. abort ends the write at once and raises no done.
// Assumes CYCLES >= 1.
module nvm_write_timer #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic abort,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] left_q;

    // Load, count down and end the write window.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            busy   <= 1'b0;
            left_q <= '0;
        end else if (start && !busy) begin
            busy   <= 1'b1;
            left_q <= CW'(CYCLES);
        end else if (busy) begin
            if (left_q == CW'(1)) begin
                busy   <= 1'b0;
                left_q <= '0;
            end else begin
                left_q <= left_q - CW'(1);
            end
        end
    end

    assign done = busy && (left_q == CW'(1)) && !abort;

endmodule

// File: rtl/nvm_cell_array.sv
// Module nvm_cell_array
// Behavioural model of the nonvolatile byte array. It has one write port,
// which commits on the clock edge, and an asynchronous read port. It has no
// reset, because the contents survive every reset.
module nvm_cell_array #(
    parameter int ADDR_BITS = 7,
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic [ADDR_BITS-1:0] waddr,
    input  logic [DATA_BITS-1:0] wdata,
    input  logic [ADDR_BITS-1:0] raddr,
    output logic [DATA_BITS-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_BITS;

    logic [DATA_BITS-1:0] cells [DEPTH];

    // Commit a byte at the end of a write.
    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/nvm_access_ctrl.sv
// Module nvm_access_ctrl
// Register front end for the data EEPROM. It holds the pointer, data and
// control registers, decodes the key register, issues one-cycle reads and
// self-timed writes, and keeps the completion flag. All resets are
// synchronous and active low. Power-on reset wins over the warm resets.
module nvm_access_ctrl #(
    parameter int BUS_BITS     = 8,
    parameter int ADDR_BITS    = 7,
    parameter int WRITE_CYCLES = 16
) (
    input  logic                clk,
    input  logic                por_n,
    input  logic                mclr_n,
    input  logic                wdt_n,
    input  logic                bus_we,
    input  logic [1:0]          bus_sel,
    input  logic [BUS_BITS-1:0] bus_wdata,
    output logic [BUS_BITS-1:0] bus_rdata,
    input  logic                irq_clr,
    output logic                irq_flag
);
    import nvm_pkg::*;

    logic                warm;
    logic                seq_rst_n;
    logic [BUS_BITS-1:0] addr_q;
    logic [BUS_BITS-1:0] data_q;
    logic                err_q;
    logic                wren_q;
    logic                rd_q;
    logic                wr_busy;
    logic                wr_done;
    logic                key_armed;
    logic                ctrl_wr;
    logic                wr_start;
    logic                rd_start;
    logic [BUS_BITS-1:0] cell_rdata;

    assign warm      = !mclr_n || !wdt_n;
    assign seq_rst_n = por_n && !warm;
    assign ctrl_wr   = bus_we && (bus_sel == SEL_CTRL);
    assign wr_start  = ctrl_wr && bus_wdata[CTRL_WR] && wren_q && key_armed && !wr_busy;
    assign rd_start  = ctrl_wr && bus_wdata[CTRL_RD] && !wr_busy && !wr_start && !rd_q;

    nvm_key_seq #(
        .BUS_BITS (BUS_BITS)
    ) u_key (
        .clk       (clk),
        .rst_n     (seq_rst_n),
        .bus_we    (bus_we),
        .bus_sel   (bus_sel),
        .bus_wdata (bus_wdata),
        .armed     (key_armed)
    );

    nvm_write_timer #(
        .CYCLES (WRITE_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst_n (por_n),
        .abort (warm),
        .start (wr_start),
        .busy  (wr_busy),
        .done  (wr_done)
    );

    nvm_cell_array #(
        .ADDR_BITS (ADDR_BITS),
        .DATA_BITS (BUS_BITS)
    ) u_cells (
        .clk   (clk),
        .we    (wr_done),
        .waddr (addr_q[ADDR_BITS-1:0]),
        .wdata (data_q),
        .raddr (addr_q[ADDR_BITS-1:0]),
        .rdata (cell_rdata)
    );

    // Pointer and data registers; frozen during a write, cleared by any reset.
    always_ff @(posedge clk) begin
        if (!por_n || warm) begin
            addr_q <= '0;
            data_q <= '0;
        end else begin
            if (bus_we && bus_sel == SEL_PTR && !wr_busy) begin
                addr_q <= bus_wdata;
            end
            if (rd_q) begin
                data_q <= cell_rdata;
            end else if (bus_we && bus_sel == SEL_DATA && !wr_busy) begin
                data_q <= bus_wdata;
            end
        end
    end

    // Control bits: set-only read start, enable and error flag.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            err_q  <= 1'b0;
            wren_q <= 1'b0;
            rd_q   <= 1'b0;
        end else if (warm) begin
            rd_q <= 1'b0;
            if (wr_busy) begin
                err_q <= 1'b1;
            end
        end else begin
            rd_q <= rd_start;
            if (ctrl_wr) begin
                err_q  <= bus_wdata[CTRL_ERR];
                wren_q <= bus_wdata[CTRL_WREN];
            end
        end
    end

    // Sticky completion flag; a completion wins over a clear.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            irq_flag <= 1'b0;
        end else if (wr_done) begin
            irq_flag <= 1'b1;
        end else if (irq_clr) begin
            irq_flag <= 1'b0;
        end
    end

    // Read-back multiplexer for the selected register.
    always_comb begin
        bus_rdata = '0;
        case (bus_sel)
            SEL_PTR:  bus_rdata = addr_q;
            SEL_DATA: bus_rdata = data_q;
            SEL_CTRL: begin
                bus_rdata[CTRL_RD]   = rd_q;
                bus_rdata[CTRL_WR]   = wr_busy;
                bus_rdata[CTRL_WREN] = wren_q;
                bus_rdata[CTRL_ERR]  = err_q;
            end
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/nvm_access_ctrl_sva.sv
// Module nvm_access_ctrl_sva
// Temporal checks on the access controller. It is attached to every instance
// of nvm_access_ctrl by the bind statement at the end of this file.
module nvm_access_ctrl_sva #(
    parameter int BUS_BITS = 8
) (
    input logic                clk,
    input logic                por_n,
    input logic                mclr_n,
    input logic                wdt_n,
    input logic [1:0]          bus_sel,
    input logic [BUS_BITS-1:0] bus_rdata,
    input logic                busy,
    input logic                wren,
    input logic                rd,
    input logic                err,
    input logic [BUS_BITS-1:0] addr,
    input logic                irq_flag
);
    logic no_warm;
    assign no_warm = mclr_n && wdt_n;

    // R5/R8: a write ends only through completion, which raises the flag.
    assert_write_ends_with_flag_R8: assert property (@(posedge clk) disable iff (!por_n)
        busy && no_warm |=> busy || irq_flag);

    // R6: the write window opens only with the enable bit already set.
    assert_start_needs_enable_R6: assert property (@(posedge clk) disable iff (!por_n)
        $rose(busy) |-> $past(wren));

    // R4: the read start bit is high for a single cycle.
    assert_read_one_cycle_R4: assert property (@(posedge clk) disable iff (!por_n)
        rd |=> !rd);

    // R5: the pointer is frozen while a write runs.
    assert_ptr_frozen_R5: assert property (@(posedge clk) disable iff (!por_n)
        busy && no_warm |=> $stable(addr));

    // R10: a warm reset during a write leaves the error flag set.
    assert_abort_sets_err_R10: assert property (@(posedge clk) disable iff (!por_n)
        busy && !no_warm |=> err && !busy);

    // R9: the key register reads zero.
    assert_key_reads_zero_R9: assert property (@(posedge clk) disable iff (!por_n)
        bus_sel == 2'd3 |-> bus_rdata == '0);

    // R2: the unused control bits read zero.
    assert_ctrl_upper_zero_R2: assert property (@(posedge clk) disable iff (!por_n)
        bus_sel == 2'd2 |-> bus_rdata[BUS_BITS-1:4] == '0);

endmodule

bind nvm_access_ctrl nvm_access_ctrl_sva #(.BUS_BITS(BUS_BITS)) u_sva (
    .clk       (clk),
    .por_n     (por_n),
    .mclr_n    (mclr_n),
    .wdt_n     (wdt_n),
    .bus_sel   (bus_sel),
    .bus_rdata (bus_rdata),
    .busy      (wr_busy),
    .wren      (wren_q),
    .rd        (rd_q),
    .err       (err_q),
    .addr      (addr_q),
    .irq_flag  (irq_flag)
);

// File: tb/nvm_access_ctrl_test.sv
// Bench for nvm_access_ctrl: directed corner cases followed by seeded random
// writes and reads, checked against a bench-side array model.
module nvm_access_ctrl_test;
    localparam int WC = 16;
    localparam logic [1:0] S_PTR = 2'd0, S_DATA = 2'd1, S_CTRL = 2'd2, S_KEY = 2'd3;

    logic       clk = 1'b0;
    logic       por_n = 1'b0, mclr_n = 1'b1, wdt_n = 1'b1;
    logic       bus_we = 1'b0;
    logic [1:0] bus_sel = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq_clr = 1'b0;
    logic       irq_flag;

    int checks = 0;
    int fails  = 0;

    logic [7:0] mem_m [128];
    bit         val_m [128];
    bit         err_m = 1'b0, wren_m = 1'b0;

    always #5 clk = ~clk;

    nvm_access_ctrl #(.WRITE_CYCLES(WC)) uut (
        .clk(clk), .por_n(por_n), .mclr_n(mclr_n), .wdt_n(wdt_n),
        .bus_we(bus_we), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_clr(irq_clr), .irq_flag(irq_flag)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] ctrl_word(input bit wr, input bit rd);
        return {4'b0000, err_m, wren_m, wr, rd};
    endfunction

    task automatic bw(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        bus_sel = s; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rr(input logic [1:0] s, output logic [7:0] v);
        bus_sel = s;
        #1;
        v = bus_rdata;
    endtask

    task automatic start_write(input logic [7:0] a, input logic [7:0] d);
        bw(S_PTR, a);
        bw(S_DATA, d);
        wren_m = 1'b1;
        bw(S_CTRL, ctrl_word(1'b0, 1'b0));
        bw(S_KEY, 8'h55);
        bw(S_KEY, 8'hAA);
        bw(S_CTRL, ctrl_word(1'b1, 1'b0));
    endtask

    task automatic wait_idle(output int n);
        logic [7:0] c;
        n = 0;
        rr(S_CTRL, c);
        while (c[1] && n < 1000) begin
            n++;
            @(negedge clk);
            rr(S_CTRL, c);
        end
    endtask

    task automatic clear_irq();
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
        chk("R8 flag cleared", int'(irq_flag), 0);
    endtask

    task automatic full_write(input logic [7:0] a, input logic [7:0] d);
        int n;
        start_write(a, d);
        wait_idle(n);
        chk("R5 busy length", n, WC);
        chk("R8 flag after write", int'(irq_flag), 1);
        mem_m[a[6:0]] = d;
        val_m[a[6:0]] = 1'b1;
        clear_irq();
    endtask

    task automatic do_read(input logic [7:0] a, output logic [7:0] v);
        logic [7:0] c;
        bw(S_PTR, a);
        bw(S_CTRL, ctrl_word(1'b0, 1'b1));
        rr(S_CTRL, c);
        chk("R4 read start seen", int'(c[0]), 1);
        @(negedge clk);
        rr(S_CTRL, c);
        chk("R4 read start cleared", int'(c[0]), 0);
        rr(S_DATA, v);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int n;
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(negedge clk);
        por_n = 1'b1;

        // R11: power-on state
        rr(S_PTR, v);  chk("R11 ptr reset", v, 0);
        rr(S_DATA, v); chk("R11 data reset", v, 0);
        rr(S_CTRL, v); chk("R11 ctrl reset", v, 0);
        chk("R11 flag reset", int'(irq_flag), 0);

        // R9: key register has no storage
        bw(S_KEY, 8'h5A);
        rr(S_KEY, v); chk("R9 key reads zero", v, 0);

        // R2: upper control bits never stick
        bw(S_CTRL, 8'hF0);
        rr(S_CTRL, v); chk("R2 upper bits zero", v, 0);

        // R6: correct key but enable clear
        bw(S_KEY, 8'h55); bw(S_KEY, 8'hAA); bw(S_CTRL, 8'h02);
        rr(S_CTRL, v); chk("R6 no start without enable", int'(v[1]), 0);

        // R7: key broken by a data write, then swapped key order
        wren_m = 1'b1;
        bw(S_CTRL, ctrl_word(1'b0, 1'b0));
        bw(S_KEY, 8'h55); bw(S_DATA, 8'h33); bw(S_KEY, 8'hAA);
        bw(S_CTRL, ctrl_word(1'b1, 1'b0));
        rr(S_CTRL, v); chk("R7 interrupted key", int'(v[1]), 0);
        bw(S_KEY, 8'hAA); bw(S_KEY, 8'h55);
        bw(S_CTRL, ctrl_word(1'b1, 1'b0));
        rr(S_CTRL, v); chk("R7 swapped key", int'(v[1]), 0);

        // R5, R8: complete write
        full_write(8'h05, 8'hC3);

        // R1: bit 7 of the pointer is ignored by the decode
        do_read(8'h85, v);
        chk("R1 aliased read", v, 8'hC3);
        rr(S_PTR, v); chk("R1 ptr readback", v, 8'h85);

        // R3, R5: bus traffic during a write is ignored
        start_write(8'h10, 8'h7E);
        bw(S_PTR, 8'h22);
        bw(S_DATA, 8'h99);
        bw(S_CTRL, ctrl_word(1'b0, 1'b0));
        rr(S_CTRL, v); chk("R3 write start not cleared", int'(v[1]), 1);
        rr(S_PTR, v);  chk("R5 ptr frozen", v, 8'h10);
        rr(S_DATA, v); chk("R5 data frozen", v, 8'h7E);
        wait_idle(n);
        chk("R8 flag after write", int'(irq_flag), 1);
        clear_irq();
        mem_m[7'h10] = 8'h7E; val_m[7'h10] = 1'b1;
        do_read(8'h10, v); chk("R5 committed byte", v, 8'h7E);

        // R8: completion and clear in the same cycle, set wins
        start_write(8'h11, 8'h5C);
        irq_clr = 1'b1;
        wait_idle(n);
        chk("R8 set beats clear", int'(irq_flag), 1);
        irq_clr = 1'b0;
        mem_m[7'h11] = 8'h5C; val_m[7'h11] = 1'b1;
        clear_irq();

        // R10: warm reset in the middle of a write
        full_write(8'h30, 8'h11);
        start_write(8'h30, 8'hEE);
        repeat (3) @(negedge clk);
        mclr_n = 1'b0;
        @(negedge clk);
        mclr_n = 1'b1;
        err_m = 1'b1;
        rr(S_CTRL, v); chk("R10 err set wren kept", v, 8'h0C);
        rr(S_PTR, v);  chk("R10 ptr cleared", v, 0);
        rr(S_DATA, v); chk("R10 data cleared", v, 0);
        repeat (WC + 2) @(negedge clk);
        chk("R10 no flag on abort", int'(irq_flag), 0);
        do_read(8'h30, v); chk("R10 location kept", v, 8'h11);

        // R11: warm reset while idle keeps err and enable; POR clears them
        wdt_n = 1'b0; @(negedge clk); wdt_n = 1'b1;
        rr(S_CTRL, v); chk("R11 warm keeps bits", v, 8'h0C);
        por_n = 1'b0; @(negedge clk); por_n = 1'b1;
        err_m = 1'b0; wren_m = 1'b0;
        rr(S_CTRL, v); chk("R11 por clears bits", v, 0);

        // Random writes and reads over a few aliased locations (R1, R4, R5)
        for (int i = 0; i < 40; i++) begin
            logic [7:0] a;
            a = {1'($urandom), 4'b0000, 3'($urandom)};
            if ($urandom % 2 == 0) begin
                full_write(a, 8'($urandom));
            end
            a = {1'($urandom), 4'b0000, 3'($urandom)};
            do_read(a, v);
            if (val_m[a[6:0]]) chk("R1 random read", v, mem_m[a[6:0]]);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule